// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a small microcontroller between a running state and five sleep levels of increasing depth: S0 (CPU halted), S3 (standby), S4 (off with RAM kept), S35 (only the RTC counter and the display supplied) and S45 (shutdown). Software writes a level code. The sequencer then drives a fixed set of clock permits, memory and core power enables and an I/O hold line, taken from a per-level table. The clock system ANDs each clock permit with its own enable, so a permit of 1 means the clock may run.

A wake event is accepted only when it is a legal source for the current level. A cycle counter clocked from a reference of `REF_MHZ` MHz then runs a level-specific delay. The block returns to the running state and emits a one-cycle ready strobe.

- **S0 and S3** are interrupt-driven. When the handler returns, the system drops back into the same level.
- **S35 and S45** have lost core supply. Leaving them produces a restart strobe instead of a resume.
- **S4** also returns to the running state, with no re-entry on handler return.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst_ni` is released the level is RUN (code 0), every permit and power enable is 1, `io_hold_o` is 0, and `waking_o`, `ready_o` and `restart_o` are 0.
- R2: Level codes on `req_mode_i` are: 0 RUN, 1 S0, 2 S3, 3 S4, 4 S35 and 5 S45. In RUN, a `req_valid_i` cycle with code 1 to 5 makes `mode_o` equal that code on the next cycle. Code 0 keeps RUN and clears any pending re-entry. Codes 6 and 7 have no effect.
- R3: Clock permits by level:
  - `mclk_en_o` is 1 only in RUN.
  - `hs_clk_allow_o` is 1 in RUN and S0 only.
  - `aux_clk_allow_o` is 1 in RUN, S0 and S3.
  - `lf_osc_allow_o` is 1 in RUN, S0, S3 and S35.
- R4: Memory, power and hold outputs by level:
  - `nvm_on_o` is 1 in RUN and S0.
  - `ram_on_o` is 1 in RUN through S4.
  - `backup_on_o` is 0 only in S45.
  - `core_pwr_o` is 0 only in S35 and S45.
  - `io_hold_o` is 1 in S3, S4, S35 and S45.
- R5: Legal wake sources are: `irq_i` in S0 and S3, `io_wake_i` in S4 and S45, and `rtc_wake_i` or `io_wake_i` in S35. Any other source leaves the level unchanged and does not start a wake.
- R6: A legal wake sampled at edge k makes `mode_o` return to 0 at edge k+N. N is 1 for S0, 10·REF_MHZ for S3 and S4, and 150·REF_MHZ for S35 and S45. In between, `waking_o` is 1 and the outputs keep the sleep level's values.
- R7: In the first RUN cycle after a wake, `ready_o` is 1 for exactly one cycle and `io_hold_o` is already 0.
- R8: After a wake from S0 or S3, a `reti_i` cycle in RUN re-enters that level on the next cycle. A code-0 request cancels this re-entry, and `reti_i` with nothing pending has no effect.
- R9: `restart_o` pulses together with `ready_o` after a wake from S35 or S45 and stays 0 for the other levels. After a wake from S4, S35 or S45, `reti_i` has no effect.
- R10: Requests arriving while asleep or during the wake delay are ignored. They change neither the level nor the wake timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock for the sequencer and delay counter |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Level-request write strobe |
| req_mode_i | input | 3 | Requested level code |
| irq_i | input | 1 | Any enabled interrupt pending |
| io_wake_i | input | 1 | I/O wake event |
| rtc_wake_i | input | 1 | RTC counter wake event |
| reti_i | input | 1 | Interrupt handler return strobe |
| mode_o | output | 3 | Current level code |
| mclk_en_o | output | 1 | CPU clock enable |
| hs_clk_allow_o | output | 1 | Permit for sub-system clock, FLL, DCO and module clock |
| aux_clk_allow_o | output | 1 | Permit for auxiliary clock and reference oscillator |
| lf_osc_allow_o | output | 1 | Permit for crystal and very-low-power oscillators |
| nvm_on_o | output | 1 | Program memory powered |
| ram_on_o | output | 1 | RAM retained |
| backup_on_o | output | 1 | Backup register file retained |
| core_pwr_o | output | 1 | Core supply on |
| io_hold_o | output | 1 | Digital I/O outputs latched |
| waking_o | output | 1 | Wake delay running |
| ready_o | output | 1 | One-cycle strobe on return to RUN |
| restart_o | output | 1 | One-cycle strobe marking a restart from S35 or S45 |

## Verification
On every cycle, the assertions check these properties:
- The I/O hold never coexists with the CPU clock.
- RAM is never kept without core supply.
- The ready and restart strobes are single pulses, aligned to RUN.
- A restart only follows S35 or S45.
- Requests made while asleep cannot move the level except back to RUN.
- S4 stays put without an I/O event.

Only the bench scenarios can show the rest:
- The exact wake delay per level.
- The full gating table per level.
- Rejection of each illegal source.
- Re-entry after handler return, and its cancellation.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    M_RUN = 3'd0,
    M_S0  = 3'd1,
    M_S3  = 3'd2,
    M_S4  = 3'd3,
    M_S35 = 3'd4,
    M_S45 = 3'd5
  } pmode_e;

  typedef struct packed {
    logic mclk;
    logic hs_clk;
    logic aux_clk;
    logic lf_osc;
    logic nvm;
    logic ram;
    logic backup;
    logic core;
    logic io_hold;
  } gate_t;

  localparam logic [2:0] MAX_CODE = 3'd5;
endpackage

// File: rtl/pmode_table.sv
module pmode_table
  import pwr_mode_pkg::*;
(
  input  pmode_e mode_i,
  output gate_t  gate_o
);
  always_comb begin
    unique case (mode_i)
      M_RUN:   gate_o = '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0};
      M_S0:    gate_o = '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0};
      M_S3:    gate_o = '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1};
      M_S4:    gate_o = '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1};
      M_S35:   gate_o = '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1};
      M_S45:   gate_o = '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1};
      default: gate_o = '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0};
    endcase
  end
endmodule

// File: rtl/wake_qual.sv
module wake_qual
  import pwr_mode_pkg::*;
(
  input  pmode_e mode_i,
  input  logic   irq_i,
  input  logic   io_wake_i,
  input  logic   rtc_wake_i,
  output logic   hit_o
);
  always_comb begin
    unique case (mode_i)
      M_S0, M_S3:  hit_o = irq_i;
      M_S4, M_S45: hit_o = io_wake_i;
      M_S35:       hit_o = io_wake_i | rtc_wake_i;
      default:     hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import pwr_mode_pkg::*;
#(
  parameter int unsigned LAT_S0   = 1,
  parameter int unsigned LAT_MID  = 10,
  parameter int unsigned LAT_DEEP = 150,
  parameter int unsigned CNT_W    = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  pmode_e mode_i,
  output logic   busy_o,
  output logic   done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;
  logic             busy_q;

  // load is latency-1: done fires on the Nth edge after start
  always_comb begin
    unique case (mode_i)
      M_S0:        load = CNT_W'(LAT_S0 - 1);
      M_S3, M_S4:  load = CNT_W'(LAT_MID - 1);
      M_S35, M_S45: load = CNT_W'(LAT_DEEP - 1);
      default:     load = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= load;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int unsigned REF_MHZ = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_mode_i,
  input  logic       irq_i,
  input  logic       io_wake_i,
  input  logic       rtc_wake_i,
  input  logic       reti_i,
  output logic [2:0] mode_o,
  output logic       mclk_en_o,
  output logic       hs_clk_allow_o,
  output logic       aux_clk_allow_o,
  output logic       lf_osc_allow_o,
  output logic       nvm_on_o,
  output logic       ram_on_o,
  output logic       backup_on_o,
  output logic       core_pwr_o,
  output logic       io_hold_o,
  output logic       waking_o,
  output logic       ready_o,
  output logic       restart_o
);
  localparam int unsigned LAT_S0   = 1;
  localparam int unsigned LAT_MID  = 10 * REF_MHZ;
  localparam int unsigned LAT_DEEP = 150 * REF_MHZ;
  localparam int unsigned CNT_W    = $clog2(LAT_DEEP + 1);

  pmode_e mode_q, resume_q;
  logic   ready_q, restart_q;
  logic   hit, busy, done, start;
  gate_t  gate;

  wake_qual i_qual (
    .mode_i    (mode_q),
    .irq_i     (irq_i),
    .io_wake_i (io_wake_i),
    .rtc_wake_i(rtc_wake_i),
    .hit_o     (hit)
  );

  assign start = (mode_q != M_RUN) && !busy && hit;

  wake_timer #(
    .LAT_S0  (LAT_S0),
    .LAT_MID (LAT_MID),
    .LAT_DEEP(LAT_DEEP),
    .CNT_W   (CNT_W)
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .mode_i (mode_q),
    .busy_o (busy),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_RUN;
      resume_q  <= M_RUN;
      ready_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      ready_q   <= 1'b0;
      restart_q <= 1'b0;
      if (mode_q == M_RUN) begin
        if (req_valid_i && req_mode_i <= MAX_CODE) begin
          mode_q   <= pmode_e'(req_mode_i);
          resume_q <= M_RUN;
        end else if (reti_i && resume_q != M_RUN) begin
          mode_q <= resume_q;
        end
      end else if (done) begin
        mode_q    <= M_RUN;
        ready_q   <= 1'b1;
        restart_q <= (mode_q == M_S35) || (mode_q == M_S45);
        resume_q  <= (mode_q == M_S0 || mode_q == M_S3) ? mode_q : M_RUN;
      end
    end
  end

  pmode_table i_table (
    .mode_i(mode_q),
    .gate_o(gate)
  );

  assign mode_o          = mode_q;
  assign mclk_en_o       = gate.mclk;
  assign hs_clk_allow_o  = gate.hs_clk;
  assign aux_clk_allow_o = gate.aux_clk;
  assign lf_osc_allow_o  = gate.lf_osc;
  assign nvm_on_o        = gate.nvm;
  assign ram_on_o        = gate.ram;
  assign backup_on_o     = gate.backup;
  assign core_pwr_o      = gate.core;
  assign io_hold_o       = gate.io_hold;
  assign waking_o        = busy;
  assign ready_o         = ready_q;
  assign restart_o       = restart_q;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       io_wake_i,
  input logic [2:0] mode_o,
  input logic       mclk_en_o,
  input logic       ram_on_o,
  input logic       core_pwr_o,
  input logic       io_hold_o,
  input logic       waking_o,
  input logic       ready_o,
  input logic       restart_o
);
  AST_HOLD_NO_MCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hold_o |-> !mclk_en_o); // R3
  AST_RAM_NEEDS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_pwr_o |-> !ram_on_o); // R4
  AST_WAKING_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waking_o |-> mode_o != 3'd0); // R6
  AST_READY_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mode_o == 3'd0 && !io_hold_o && !waking_o)); // R7
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R7
  AST_RESTART_DEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (ready_o && ($past(mode_o) == 3'd4 || $past(mode_o) == 3'd5))); // R9
  AST_REQ_ASLEEP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd0 && req_valid_i) |=> (mode_o == $past(mode_o) || mode_o == 3'd0)); // R10
  AST_S4_IO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && !waking_o && !io_wake_i) |=> mode_o == 3'd3); // R5
endmodule

bind pwr_mode_seq pwr_mode_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .io_wake_i  (io_wake_i),
  .mode_o     (mode_o),
  .mclk_en_o  (mclk_en_o),
  .ram_on_o   (ram_on_o),
  .core_pwr_o (core_pwr_o),
  .io_hold_o  (io_hold_o),
  .waking_o   (waking_o),
  .ready_o    (ready_o),
  .restart_o  (restart_o)
);

// File: tb/test_pwr_mode_seq.sv
`timescale 1ns/1ps
module test_pwr_mode_seq;
  localparam int REF_MHZ = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, irq = 1'b0, io_wake = 1'b0, rtc_wake = 1'b0, reti = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic [2:0] mode;
  logic mclk, hs, aux, lf, nvm, ram, bkp, core, hold, waking, ready, restart;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.REF_MHZ(REF_MHZ)) i_pwr_mode_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .irq_i(irq), .io_wake_i(io_wake), .rtc_wake_i(rtc_wake), .reti_i(reti),
    .mode_o(mode), .mclk_en_o(mclk), .hs_clk_allow_o(hs), .aux_clk_allow_o(aux),
    .lf_osc_allow_o(lf), .nvm_on_o(nvm), .ram_on_o(ram), .backup_on_o(bkp),
    .core_pwr_o(core), .io_hold_o(hold), .waking_o(waking), .ready_o(ready),
    .restart_o(restart)
  );

  function automatic logic [8:0] exp_gate(int m);
    case (m)
      0: return 9'b1_1111_1110;
      1: return 9'b0_1111_1110;
      2: return 9'b0_0110_1111;
      3: return 9'b0_0000_1111;
      4: return 9'b0_0010_0101;
      default: return 9'b0_0000_0001;
    endcase
  endfunction

  function automatic int exp_lat(int m);
    if (m == 1) return 1;
    if (m == 2 || m == 3) return 10 * REF_MHZ;
    return 150 * REF_MHZ;
  endfunction

  // src: 0 irq, 1 io, 2 rtc
  function automatic bit legal(int m, int src);
    case (m)
      1, 2: return src == 0;
      3, 5: return src == 1;
      4: return src != 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [8:0] gates();
    return {mclk, hs, aux, lf, nvm, ram, bkp, core, hold};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_req(int code);
    req_valid = 1'b1; req_mode = 3'(code);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1;
    @(posedge clk); @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic set_src(int src, logic v);
    case (src)
      0: irq = v;
      1: io_wake = v;
      default: rtc_wake = v;
    endcase
  endtask

  task automatic wake_measure(int m, int src);
    int n = 0;
    set_src(src, 1'b1);
    @(posedge clk); @(negedge clk);
    set_src(src, 1'b0);
    while (mode != 3'd0 && n < 1000) begin
      chk(waking == 1'b1 && mode == 3'(m), "R6 waking", {waking, mode}, {1'b1, 3'(m)});
      chk(gates() == exp_gate(m), "R6 gating held", gates(), exp_gate(m));
      if (n == 2) begin req_valid = 1'b1; req_mode = 3'($urandom_range(1, 5)); end
      @(posedge clk); n++;
      @(negedge clk);
      req_valid = 1'b0;
    end
    chk(n == exp_lat(m), "R6 latency", n, exp_lat(m));
    chk(n <= 2 || mode == 3'd0, "R10 req during wake", mode, 0);
    chk(ready == 1'b1 && hold == 1'b0, "R7 ready", {ready, hold}, 2'b10);
    chk(restart == (m >= 4), "R9 restart", restart, m >= 4);
    chk(gates() == exp_gate(0), "R3 R4 run gating", gates(), exp_gate(0));
    @(posedge clk); @(negedge clk);
    chk(ready == 1'b0 && restart == 1'b0, "R7 pulse", {ready, restart}, 0);
  endtask

  task automatic run_mode(int m, int wsrc);
    pulse_req(0);
    pulse_req(m);
    chk(mode == 3'(m), "R2 enter", mode, m);
    chk(gates() == exp_gate(m), "R3 R4 table", gates(), exp_gate(m));
    pulse_req(m == 1 ? 2 : 1);
    chk(mode == 3'(m), "R10 req asleep", mode, m);
    for (int s = 0; s < 3; s++) begin
      if (!legal(m, s)) begin
        set_src(s, 1'b1);
        @(posedge clk); @(negedge clk);
        set_src(s, 1'b0);
        @(posedge clk); @(negedge clk);
        chk(mode == 3'(m) && !waking, "R5 illegal source", {waking, mode}, m);
      end
    end
    wake_measure(m, wsrc);
    pulse_reti();
    if (m <= 2) begin
      chk(mode == 3'(m), "R8 re-entry", mode, m);
      wake_measure(m, 0);
      pulse_req(0);
      pulse_reti();
      chk(mode == 3'd0, "R8 cancel", mode, 0);
    end else begin
      chk(mode == 3'd0, "R9 no re-entry", mode, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 3'd0 && gates() == exp_gate(0), "R1 reset", {gates(), mode}, {exp_gate(0), 3'd0});
    chk(!waking && !ready && !restart, "R1 strobes", {waking, ready, restart}, 0);
    pulse_req(6);
    chk(mode == 3'd0, "R2 code 6", mode, 0);
    pulse_req(7);
    chk(mode == 3'd0, "R2 code 7", mode, 0);
    pulse_reti();
    chk(mode == 3'd0, "R8 reti idle", mode, 0);
    for (int m = 1; m <= 5; m++) run_mode(m, (m == 1 || m == 2) ? 0 : 1);
    run_mode(4, 2);
    for (int i = 0; i < 12; i++) begin
      int m = $urandom_range(1, 5);
      int s;
      do s = $urandom_range(0, 2); while (!legal(m, s));
      run_mode(m, s);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule